// File: doc/BRIEF.md
# Four-Phase Handshake Word Link

This block carries parallel data words from a producing side to a consuming side when the two run on unrelated clocks. It contains a sending unit and a receiving unit. Each has its own clock and reset. They are joined only by a data bus and two handshake lines. A local push port feeds the sender and a local pop port drains a one-word holding slot in the receiver. Each incoming handshake line passes through a chain of synchronizer flops before any state machine uses it.

Two orderings are supported, and the choice is made by a static mode input. With `dest_mode` = 0 the sender opens each exchange. It puts the word on the bus, raises its valid line and waits for the receiver's accept line. It then lowers valid and waits for accept to fall. With `dest_mode` = 1 the receiver opens each exchange. It raises its ready line and the sender answers with data and valid. The receiver captures the word and lowers ready. The sender then lowers valid, and the receiver sees valid low before it offers again. Either side may pause for any number of cycles between steps.

Each side has a watchdog with a programmable cycle limit. The watchdog restarts whenever its side takes a handshake step. If a side stays too long in a step that needs an answer from the partner, it raises a sticky timeout flag. It then drops its own handshake line and goes back to idle.

Top module: `hs_link`

## Requirements
- R1: While reset is held, `pop_valid`, `src_timeout` and `dst_timeout` are 0. `push_ready` is 1 when `dest_mode` = 0 and 0 when `dest_mode` = 1.
- R2: With `dest_mode` = 0, every word accepted at the push port leaves the pop port exactly once and in push order, for any delays at either port and any ratio between the two clocks.
- R3: With `dest_mode` = 1, every word accepted at the push port leaves the pop port exactly once and in push order. The receiver raises ready only while its slot is empty and the synchronized valid line is low.
- R4: The sender loads the bus at least one sender cycle before valid rises. It holds the bus stable while valid is high and drives all zeros once the word is retired.
- R5: The sender lowers valid only in two cases. The first is that the synchronized reply shows the partner has responded: accept high in mode 0, or ready low in mode 1. The second is that its watchdog has expired.
- R6: The receiver captures only when the synchronized valid line is high and its slot is empty. Valid must also have been seen low since the previous capture or expiry. A word that has not been popped is never overwritten.
- R7: `pop_valid` and `pop_data` hold unchanged until the cycle in which `pop_ready` is high.
- R8: If the sender spends more than `tmo_limit` sender cycles waiting in one step, `src_timeout` sets and the sender returns to idle, with `push_ready` high again in mode 0. The flag does not set before the limit has passed.
- R9: If the receiver holds a captured exchange open for more than `tmo_limit` receiver cycles, `dst_timeout` sets and the receiver drops its reply line. A valid line that stays high is not captured a second time.
- R10: A `tmo_limit` of 0 disables both watchdogs, however long a stall lasts.
- R11: Timeout flags stay set until reset, and words still pass normally while a flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Sender clock |
| rst_src_n | input | 1 | Sender synchronous reset, active low |
| clk_dst | input | 1 | Receiver clock |
| rst_dst_n | input | 1 | Receiver synchronous reset, active low |
| dest_mode | input | 1 | 0: sender opens each exchange; 1: receiver opens it (change only in reset) |
| tmo_limit | input | TMO_W | Watchdog limit in local cycles; 0 disables |
| push_valid | input | 1 | Word offered to the sender |
| push_data | input | DATA_W | Offered word |
| push_ready | output | 1 | Sender takes the word on this edge if push_valid |
| pop_valid | output | 1 | Receiver slot holds a word |
| pop_data | output | DATA_W | Word in the receiver slot |
| pop_ready | input | 1 | Consumer takes the slot word on this edge |
| src_timeout | output | 1 | Sticky sender watchdog flag |
| dst_timeout | output | 1 | Sticky receiver watchdog flag |

## Verification
The reset-state outputs are read while reset is still held, because they depend only on registers that reset sets. A word pushed on one sender edge can reach `pop_valid` only after the sender's setup cycle, its valid register, and the receiver's synchronizer and capture register. The crossing makes the exact receiver cycle vary, so the bench does not check delivery at a fixed edge. It samples the pop port at every receiver falling edge and checks order and count as the words come out. A watchdog flag is due one cycle after more than `tmo_limit` cycles spent in one step. The bench checks the flag is still low well before that point and high after a fixed margin past it. Ports are always sampled at falling edges.

// File: rtl/hs_pkg.sv
// hs_pkg: state encodings shared by the sender and receiver units.
// Assumes: nothing; pure type definitions.
package hs_pkg;
    typedef enum logic [1:0] {
        SRC_IDLE       = 2'd0,
        SRC_SETUP      = 2'd1,
        SRC_WAIT_REPLY = 2'd2,
        SRC_WAIT_CLEAR = 2'd3
    } src_state_e;

    typedef enum logic [1:0] {
        DST_IDLE  = 2'd0,
        DST_OFFER = 2'd1,
        DST_HOLD  = 2'd2
    } dst_state_e;
endpackage

// File: rtl/hs_sync.sv
// hs_sync: multi-flop synchronizer for one asynchronous level signal.
// Assumes: input is a slow level (handshake line); STAGES >= 2.
module hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // shift the incoming level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hs_watchdog.sv
// hs_watchdog: counts cycles spent in one waiting step and flags expiry.
// Assumes: step_i pulses whenever the owning state machine changes state;
// a limit of zero disables expiry.
module hs_watchdog #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             active_i,
    input  logic             step_i,
    output logic             expire_o,
    output logic             err_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;

    assign expire_o = active_i && (limit_i != '0) && (cnt_q == limit_i);
    assign err_o    = err_q;

    // count cycles in the current step, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (step_i || !active_i) cnt_q <= '0;
        else if (cnt_q != limit_i)  cnt_q <= cnt_q + 1'b1;
    end

    // sticky error flag, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)        err_q <= 1'b0;
        else if (expire_o) err_q <= 1'b1;
    end

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(err_q));

    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(active_i && (limit_i != '0)));
endmodule

// File: rtl/hs_source.sv
// hs_source: sending side of the four-phase link. Takes a word from the
// push port, presents it on the bus, raises valid and walks the handshake.
// Assumes: dest_mode_i is static outside reset; reply_i is asynchronous.
module hs_source
    import hs_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int TMO_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dest_mode_i,
    input  logic [TMO_W-1:0]  tmo_limit_i,
    input  logic              push_valid_i,
    input  logic [DATA_W-1:0] push_data_i,
    output logic              push_ready_o,
    input  logic              reply_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] bus_o,
    output logic              tmo_err_o
);
    src_state_e        st_q, st_d;
    logic              reply_s;
    logic              valid_q;
    logic [DATA_W-1:0] bus_q;
    logic              start_ok, answered, waiting, expire, step;

    hs_sync #(.STAGES(SYNC_STAGES)) u_reply_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (reply_i),
        .q_o   (reply_s)
    );

    // mode-dependent meaning of the reply line
    always_comb begin
        start_ok = dest_mode_i ? reply_s  : !reply_s;
        answered = dest_mode_i ? !reply_s : reply_s;
        waiting  = (st_q == SRC_WAIT_REPLY) || (st_q == SRC_WAIT_CLEAR);
    end

    assign push_ready_o = (st_q == SRC_IDLE) && start_ok;

    // next-state logic of the sender handshake
    always_comb begin
        st_d = st_q;
        case (st_q)
            SRC_IDLE:       if (push_valid_i && push_ready_o) st_d = SRC_SETUP;
            SRC_SETUP:      st_d = SRC_WAIT_REPLY;
            SRC_WAIT_REPLY: begin
                if (expire)        st_d = SRC_IDLE;
                else if (answered) st_d = dest_mode_i ? SRC_IDLE : SRC_WAIT_CLEAR;
            end
            SRC_WAIT_CLEAR: if (expire || !reply_s) st_d = SRC_IDLE;
            default:        st_d = SRC_IDLE;
        endcase
    end

    assign step = (st_d != st_q);

    hs_watchdog #(.CNT_W(TMO_W)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .limit_i  (tmo_limit_i),
        .active_i (waiting),
        .step_i   (step),
        .expire_o (expire),
        .err_o    (tmo_err_o)
    );

    // state, valid line and bus register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SRC_IDLE;
            valid_q <= 1'b0;
            bus_q   <= '0;
        end else begin
            st_q    <= st_d;
            valid_q <= (st_d == SRC_WAIT_REPLY);
            if (st_q == SRC_IDLE && st_d == SRC_SETUP)
                bus_q <= push_data_i;
            else if (st_d == SRC_IDLE || st_d == SRC_WAIT_CLEAR)
                bus_q <= '0;
        end
    end

    assign valid_o = valid_q;
    assign bus_o   = bus_q;

    // R4
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && $past(valid_q)) |-> $stable(bus_q));

    // R4
    bus_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> $stable(bus_q));

    // R5
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid_q) |-> $past(expire || answered));
endmodule

// File: rtl/hs_dest.sv
// hs_dest: receiving side of the four-phase link. Captures the bus into a
// one-word slot and answers with accept (mode 0) or offers ready (mode 1).
// Assumes: bus is stable whenever the synchronized valid line is high.
module hs_dest
    import hs_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int TMO_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dest_mode_i,
    input  logic [TMO_W-1:0]  tmo_limit_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic              reply_o,
    output logic              pop_valid_o,
    output logic [DATA_W-1:0] pop_data_o,
    input  logic              pop_ready_i,
    output logic              tmo_err_o
);
    dst_state_e        st_q, st_d;
    logic              valid_s;
    logic              armed_q;
    logic              reply_q;
    logic              hold_full_q;
    logic [DATA_W-1:0] hold_data_q;
    logic              capture, expire, step, holding;

    hs_sync #(.STAGES(SYNC_STAGES)) u_valid_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (valid_i),
        .q_o   (valid_s)
    );

    assign holding = (st_q == DST_HOLD);

    // next-state logic of the receiver handshake
    always_comb begin
        st_d = st_q;
        case (st_q)
            DST_IDLE: begin
                if (!dest_mode_i) begin
                    if (valid_s && armed_q && !hold_full_q) st_d = DST_HOLD;
                end else if (!hold_full_q && !valid_s) begin
                    st_d = DST_OFFER;
                end
            end
            DST_OFFER: if (valid_s) st_d = DST_HOLD;
            DST_HOLD:  if (expire || !valid_s) st_d = DST_IDLE;
            default:   st_d = DST_IDLE;
        endcase
    end

    assign capture = (st_d == DST_HOLD) && (st_q != DST_HOLD);
    assign step    = (st_d != st_q);

    hs_watchdog #(.CNT_W(TMO_W)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .limit_i  (tmo_limit_i),
        .active_i (holding),
        .step_i   (step),
        .expire_o (expire),
        .err_o    (tmo_err_o)
    );

    // state, reply line and capture arming
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= DST_IDLE;
            reply_q <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            reply_q <= dest_mode_i ? (st_d == DST_OFFER) : (st_d == DST_HOLD);
            if (!valid_s)              armed_q <= 1'b1;
            else if (st_d == DST_HOLD) armed_q <= 1'b0;
        end
    end

    // one-word holding slot toward the pop port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full_q <= 1'b0;
            hold_data_q <= '0;
        end else if (capture) begin
            hold_full_q <= 1'b1;
            hold_data_q <= bus_i;
        end else if (hold_full_q && pop_ready_i) begin
            hold_full_q <= 1'b0;
        end
    end

    assign reply_o     = reply_q;
    assign pop_valid_o = hold_full_q;
    assign pop_data_o  = hold_data_q;

    // R6
    capture_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_full_q) |-> $past(valid_s));

    // R7
    pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold_full_q && !pop_ready_i) |-> (hold_full_q && $stable(hold_data_q)));

    // R2
    accept_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(reply_q) && !dest_mode_i) |-> $past(valid_s));

    // R3
    offer_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(reply_q) && dest_mode_i) |-> $past(!valid_s && !hold_full_q));
endmodule

// File: rtl/hs_link.sv
// hs_link: top of the four-phase word link; one sender and one receiver on
// independent clocks joined by a data bus and two handshake lines.
// Assumes: dest_mode and tmo_limit are changed only while both resets are held.
module hs_link #(
    parameter int DATA_W      = 16,
    parameter int TMO_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_src,
    input  logic              rst_src_n,
    input  logic              clk_dst,
    input  logic              rst_dst_n,
    input  logic              dest_mode,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pop_data,
    input  logic              pop_ready,
    output logic              src_timeout,
    output logic              dst_timeout
);
    logic              line_valid;
    logic              line_reply;
    logic [DATA_W-1:0] line_bus;

    hs_source #(
        .DATA_W(DATA_W), .TMO_W(TMO_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_source (
        .clk          (clk_src),
        .rst_n        (rst_src_n),
        .dest_mode_i  (dest_mode),
        .tmo_limit_i  (tmo_limit),
        .push_valid_i (push_valid),
        .push_data_i  (push_data),
        .push_ready_o (push_ready),
        .reply_i      (line_reply),
        .valid_o      (line_valid),
        .bus_o        (line_bus),
        .tmo_err_o    (src_timeout)
    );

    hs_dest #(
        .DATA_W(DATA_W), .TMO_W(TMO_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_dest (
        .clk         (clk_dst),
        .rst_n       (rst_dst_n),
        .dest_mode_i (dest_mode),
        .tmo_limit_i (tmo_limit),
        .valid_i     (line_valid),
        .bus_i       (line_bus),
        .reply_o     (line_reply),
        .pop_valid_o (pop_valid),
        .pop_data_o  (pop_data),
        .pop_ready_i (pop_ready),
        .tmo_err_o   (dst_timeout)
    );
endmodule

// File: tb/test_hs_link.sv
`timescale 1ns/10ps
module test_hs_link;
    localparam int DW = 16;
    localparam int TW = 16;

    typedef struct packed {
        logic mode;
        int   words;
        int   pgap;
        int   cgap;
        int   dhalf_x10;
    } row_t;

    localparam row_t ROWS [6] = '{
        '{1'b0, 40, 6,  6,  35},
        '{1'b0, 40, 0,  12, 20},
        '{1'b0, 30, 15, 0,  61},
        '{1'b1, 40, 6,  6,  35},
        '{1'b1, 40, 0,  12, 17},
        '{1'b1, 30, 15, 0,  61}
    };

    logic          clk_src = 1'b0, clk_dst = 1'b0;
    logic          rst_src_n = 1'b0, rst_dst_n = 1'b0;
    logic          dest_mode = 1'b0;
    logic [TW-1:0] tmo_limit = '0;
    logic          push_valid = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic          push_ready;
    logic          pop_valid;
    logic [DW-1:0] pop_data;
    logic          pop_ready = 1'b0;
    logic          src_timeout, dst_timeout;

    bit      src_run = 1'b1;
    realtime dst_half = 3.5;
    int      n_chk = 0, n_fail = 0;

    hs_link #(.DATA_W(DW), .TMO_W(TW)) i_hs_link (
        .clk_src(clk_src), .rst_src_n(rst_src_n), .clk_dst(clk_dst), .rst_dst_n(rst_dst_n),
        .dest_mode(dest_mode), .tmo_limit(tmo_limit),
        .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
        .pop_valid(pop_valid), .pop_data(pop_data), .pop_ready(pop_ready),
        .src_timeout(src_timeout), .dst_timeout(dst_timeout)
    );

    // 200 MHz sender clock, can be frozen to emulate a dead partner
    initial forever begin #2.5; if (src_run) clk_src = ~clk_src; end
    // receiver clock with a per-test period
    initial forever begin #(dst_half); clk_dst = ~clk_dst; end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    // reset both sides; reset-state outputs are checked while reset is held
    task automatic do_reset(input logic mode, input logic [TW-1:0] lim);
        rst_src_n = 1'b0; rst_dst_n = 1'b0;
        push_valid = 1'b0; pop_ready = 1'b0;
        dest_mode = mode; tmo_limit = lim;
        repeat (4) @(negedge clk_src);
        repeat (4) @(negedge clk_dst);
        // R1
        chk(pop_valid == 1'b0, "R1 pop_valid in reset", 32'(pop_valid), 0);
        chk(src_timeout == 1'b0 && dst_timeout == 1'b0, "R1 timeout flags in reset",
            {src_timeout, dst_timeout}, 0);
        chk(push_ready == !mode, "R1 push_ready in reset", 32'(push_ready), 32'(!mode));
        @(negedge clk_src); rst_src_n = 1'b1;
        @(negedge clk_dst); rst_dst_n = 1'b1;
        repeat (2) @(negedge clk_src);
    endtask

    task automatic push_word(input logic [DW-1:0] d);
        @(negedge clk_src);
        while (!push_ready) @(negedge clk_src);
        push_valid = 1'b1; push_data = d;
        @(negedge clk_src);
        push_valid = 1'b0;
    endtask

    task automatic push_stream(input int r, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            repeat ($urandom_range(gap, 0)) @(negedge clk_src);
            push_word(DW'(r * 4096 + i));
        end
    endtask

    task automatic pop_stream(input int r, input int n, input int gap, input string tag);
        int got = 0;
        while (got < n) begin
            @(negedge clk_dst);
            pop_ready = 1'b0;
            if (pop_valid && ($urandom_range(gap, 0) == 0)) begin
                chk(pop_data == DW'(r * 4096 + got), tag, 32'(pop_data), 32'(r * 4096 + got));
                pop_ready = 1'b1;
                got++;
            end
        end
        @(negedge clk_dst);
        pop_ready = 1'b0;
    endtask

    // pop one word with bounded waiting and compare
    task automatic pop_one(input logic [DW-1:0] exp, input string tag);
        int t = 0;
        @(negedge clk_dst);
        while (!pop_valid && t < 400) begin @(negedge clk_dst); t++; end
        chk(pop_valid && pop_data == exp, tag, 32'(pop_data), 32'(exp));
        pop_ready = 1'b1;
        @(negedge clk_dst);
        pop_ready = 1'b0;
    endtask

    initial begin
        // table-driven streaming runs in both modes
        for (int r = 0; r < 6; r++) begin
            string tag;
            int    extra;
            dst_half = ROWS[r].dhalf_x10 / 10.0;
            do_reset(ROWS[r].mode, 16'd1000);
            tag = ROWS[r].mode ? "R3 R4 R5 R6 in-order word" : "R2 R4 R5 R6 in-order word";
            fork
                push_stream(r, ROWS[r].words, ROWS[r].pgap);
                pop_stream(r, ROWS[r].words, ROWS[r].cgap, tag);
            join
            extra = 0;
            repeat (60) begin @(negedge clk_dst); if (pop_valid) extra++; end
            // R2 R3 exactly once: nothing left after the last word
            chk(extra == 0, ROWS[r].mode ? "R3 no duplicate" : "R2 no duplicate", extra, 0);
            chk(!src_timeout && !dst_timeout, "R2 R3 no timeout in normal flow",
                {src_timeout, dst_timeout}, 0);
        end

        dst_half = 3.5;

        // R8 sender watchdog: receiver slot full, second word never accepted
        do_reset(1'b0, 16'd20);
        push_word(16'hA001);
        repeat (30) @(negedge clk_src);
        push_word(16'hA002);
        repeat (10) @(negedge clk_src);
        chk(src_timeout == 1'b0, "R8 flag not before limit", 32'(src_timeout), 0);
        repeat (50) @(negedge clk_src);
        chk(src_timeout == 1'b1, "R8 sender flag after stall", 32'(src_timeout), 1);
        chk(push_ready == 1'b1, "R8 sender back to idle", 32'(push_ready), 1);
        chk(dst_timeout == 1'b0, "R8 receiver flag stays low", 32'(dst_timeout), 0);
        // R6 the unpopped word was not overwritten
        chk(pop_valid && pop_data == 16'hA001, "R6 slot kept first word", 32'(pop_data), 32'hA001);
        // R7 slot still unchanged after more cycles without pop_ready
        repeat (7) @(negedge clk_dst);
        chk(pop_valid && pop_data == 16'hA001, "R7 slot held without pop", 32'(pop_data), 32'hA001);
        pop_one(16'hA001, "R6 first word popped");
        repeat (40) @(negedge clk_dst);
        chk(pop_valid == 1'b0, "R8 abandoned word not delivered", 32'(pop_valid), 0);
        // R11 flag persists and transfers continue
        push_word(16'hA003);
        pop_one(16'hA003, "R11 transfer after timeout");
        chk(src_timeout == 1'b1, "R11 sender flag sticky", 32'(src_timeout), 1);

        // R11 reset clears the flag
        do_reset(1'b0, 16'd20);
        chk(src_timeout == 1'b0, "R11 flag cleared by reset", 32'(src_timeout), 0);

        // R10 limit zero: long stall raises nothing
        do_reset(1'b0, 16'd0);
        push_word(16'hB001);
        repeat (30) @(negedge clk_src);
        push_word(16'hB002);
        repeat (300) @(negedge clk_src);
        chk(!src_timeout && !dst_timeout, "R10 no flag with limit zero",
            {src_timeout, dst_timeout}, 0);
        pop_one(16'hB001, "R10 first word after stall");
        pop_one(16'hB002, "R10 second word after stall");

        // R9 receiver watchdog: sender clock stops with valid high
        do_reset(1'b0, 16'd30);
        pop_ready = 1'b0;
        push_word(16'hC001);
        @(posedge clk_src);
        #0.5 src_run = 1'b0;
        pop_one(16'hC001, "R9 word captured before stall");
        repeat (10) @(negedge clk_dst);
        chk(dst_timeout == 1'b0, "R9 flag not before limit", 32'(dst_timeout), 0);
        begin
            int again = 0;
            pop_ready = 1'b1;
            repeat (100) begin @(negedge clk_dst); if (pop_valid) again++; end
            pop_ready = 1'b0;
            chk(dst_timeout == 1'b1, "R9 receiver flag after stall", 32'(dst_timeout), 1);
            chk(again == 0, "R9 stuck valid not recaptured", again, 0);
        end
        src_run = 1'b1;
        repeat (5) @(negedge clk_dst);

        // dest-initiated reset state and a short directed exchange
        do_reset(1'b1, 16'd50);
        push_word(16'hD001);
        pop_one(16'hD001, "R3 directed word");
        push_word(16'hD002);
        pop_one(16'hD002, "R3 directed second word");

        finish_run();
    end
endmodule